// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Driver

This block scans a multiplexed segment LCD. It keeps a local display memory of 4-bit nibbles and, for each time slot of a frame, selects one common line and works out the on/off state of every segment for that common. The result is a drive-level index for each common pin and each segment pin. An analog stage elsewhere turns each index into a voltage. The pump, the regulator and the level buffers are outside this block.

Software picks the duty (eight or four commons scanned), the bias (a 1/3 ladder with four levels or a 1/4 ladder with five levels) and the slot length through a frame-rate register. The drive polarity flips on every frame, so the panel sees no net DC. The upper segment pins fall into groups of four. Each group can be released to a general-purpose output port. The upper four commons can serve as general inputs, but only while four-common scanning is active.

Top module: `lcd_mux_drv`

## Requirements
- R1: While `rst_n` is low, the scan is held at slot 0 in the positive phase (phase 0), and the frame-rate register holds 4'b0111.
- R2: A slot lasts (rate+1)*SLOT_UNIT clock cycles. Slots run 0, 1, 2 … in order, and in every slot exactly one scanned common is selected: the common whose number equals the slot.
- R3: With `duty_quarter`=1 a frame has 4 slots, and commons 4..7 output level 0. With `duty_quarter`=0 a frame has 8 slots.
- R4: Phase toggles after the last slot of each frame. Common level with `bias_quarter`=1: selected 4 in phase 0 and 0 in phase 1; unselected 1 in phase 0 and 3 in phase 1. With `bias_quarter`=0: selected 3 in phase 0 and 0 in phase 1; unselected 1 in phase 0 and 2 in phase 1.
- R5: Segment level with `bias_quarter`=1: on gives 0 in phase 0 and 4 in phase 1; off gives 2 in either phase. With `bias_quarter`=0: on gives 0 in phase 0 and 3 in phase 1; off gives 2 in phase 0 and 1 in phase 1.
- R6: Segment s, common c is on when bit c%4 of nibble 2*s+c/4 is 1. Nibble n is written at address 0x200+n for n in 0..79. A write to any address outside 0x200..0x24F changes nothing.
- R7: Bit g of `seg_grp_port` hands segments 16+4g..19+4g to the port. Those pins then output level 0, and `seg_gp_drv` carries the matching `seg_gp_wdata` bits. When a group is not handed over, its `seg_gp_drv` bits are 0.
- R8: `com_gp_rd` equals `com_pad_in` only when `duty_quarter`=1 and `com_gp_en`=1. Otherwise it is 0.
- R9: A write through `rate_we` changes the slot length from the next slot-count decision on. Rate 0 gives slots of SLOT_UNIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low reset |
| duty_quarter | input | 1 | 1: four commons scanned, 0: eight |
| bias_quarter | input | 1 | 1: five-level ladder, 0: four-level ladder |
| rate_we | input | 1 | Frame-rate register write strobe |
| rate_wdata | input | 4 | Frame-rate register write value |
| ram_we | input | 1 | Display memory write strobe |
| ram_addr | input | 10 | Display memory write address |
| ram_wdata | input | 4 | Display memory write nibble |
| seg_grp_port | input | 6 | Per-group hand-over of segments 16..39 to the port |
| seg_gp_wdata | input | 24 | Port output values for segments 16..39 |
| com_gp_en | input | 1 | Use commons 4..7 as general inputs |
| com_pad_in | input | 4 | Pad values on commons 4..7 |
| com_lvl | output | 24 | Drive-level index, 3 bits per common |
| seg_lvl | output | 120 | Drive-level index, 3 bits per segment |
| seg_gp_drv | output | 24 | Port output values onto segments 16..39 |
| com_gp_rd | output | 4 | General input value read from commons 4..7 |

## Verification
The bench builds the block with SLOT_UNIT=1, so a slot lasts rate+1 cycles and a full frame takes between 4 and 128 cycles. This makes it possible to step through several frames, both polarities and every common slot at each rate and duty within a short run. All other parameters keep their defaults, so the full 40-segment, six-group layout and the 0x200 address window are exercised as built.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_IDLE = '0;

  // common level: sel/phase/ladder -> index
  function automatic lvl_t com_level(input logic sel, input logic ph, input logic b4);
    lvl_t top;
    top = b4 ? lvl_t'(4) : lvl_t'(3);
    if (sel) return ph ? lvl_t'(0) : top;
    return ph ? (top - lvl_t'(1)) : lvl_t'(1);
  endfunction

  // segment level: on/phase/ladder -> index
  function automatic lvl_t seg_level(input logic on, input logic ph, input logic b4);
    lvl_t top;
    top = b4 ? lvl_t'(4) : lvl_t'(3);
    if (on) return ph ? top : lvl_t'(0);
    if (b4) return lvl_t'(2);
    return ph ? lvl_t'(1) : lvl_t'(2);
  endfunction

  // last count value of a slot
  function automatic int slot_last(input logic [3:0] rate, input int unit);
    return (int'(rate) + 1) * unit - 1;
  endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_mux_pkg::*;
#(
  parameter int NCOM      = 8,
  parameter int SLOT_UNIT = 8,
  localparam int SLOT_W   = $clog2(NCOM),
  localparam int CNT_W    = $clog2(16 * SLOT_UNIT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              duty_quarter,
  input  logic [3:0]        rate,
  output logic [SLOT_W-1:0] slot,
  output logic              phase,
  output logic              slot_end,
  output logic              frame_end
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_last;
  logic [SLOT_W-1:0] slot_final;

  assign cnt_last   = CNT_W'(slot_last(rate, SLOT_UNIT));
  assign slot_final = duty_quarter ? SLOT_W'(NCOM/2 - 1) : SLOT_W'(NCOM - 1);
  assign slot_end   = (cnt >= cnt_last);
  assign frame_end  = slot_end && (slot >= slot_final);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      slot  <= '0;
      phase <= 1'b0;
    end else if (slot_end) begin
      cnt <= '0;
      if (frame_end) begin
        slot  <= '0;
        phase <= ~phase;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R4: polarity flips right after a frame closes
  a_r4_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (phase != $past(phase)));
  // R2: slot and phase hold while a slot is still running
  a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> ($stable(slot) && $stable(phase)));
endmodule

// File: rtl/lcd_seg_ram.sv
module lcd_seg_ram #(
  parameter int          NSEG   = 40,
  parameter int          NCOM   = 8,
  parameter int          ADDR_W = 10,
  parameter logic [9:0]  BASE   = 10'h200,
  localparam int         NNIB   = NSEG * (NCOM / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wdata,
  output logic [NNIB*4-1:0] nib_flat
);
  logic [3:0]        mem [NNIB];
  logic [ADDR_W-1:0] off;
  logic              hit;

  assign off = addr - ADDR_W'(BASE);
  assign hit = (addr >= ADDR_W'(BASE)) && (off < ADDR_W'(NNIB));

  always_ff @(posedge clk) begin
    for (int i = 0; i < NNIB; i++) begin
      if (we && hit && (off == ADDR_W'(i))) mem[i] <= wdata;
    end
  end

  for (genvar n = 0; n < NNIB; n++) begin : g_flat
    assign nib_flat[n*4 +: 4] = mem[n];
  end

  // R6: a write outside the window leaves the memory untouched
  a_r6_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> $stable(nib_flat));
endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
  import lcd_mux_pkg::*;
#(
  parameter int  NSEG   = 40,
  parameter int  NCOM   = 8,
  localparam int SLOT_W = $clog2(NCOM),
  localparam int NPS    = NCOM / 4,
  localparam int NNIB   = NSEG * NPS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOT_W-1:0]     slot,
  input  logic                  phase,
  input  logic                  duty_quarter,
  input  logic                  bias_quarter,
  input  logic [NNIB*4-1:0]     nib_flat,
  output logic [NCOM*LVL_W-1:0] com_raw,
  output logic [NSEG*LVL_W-1:0] seg_raw,
  output logic [NCOM-1:0]       com_sel
);
  always_comb begin
    for (int c = 0; c < NCOM; c++) begin
      logic scanned;
      scanned    = !duty_quarter || (c < NCOM/2);
      com_sel[c] = scanned && (int'(slot) == c);
      com_raw[c*LVL_W +: LVL_W] = scanned ?
        com_level(com_sel[c], phase, bias_quarter) : LVL_IDLE;
    end
  end

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      int bi;
      bi = (s * NPS + int'(slot) / 4) * 4 + int'(slot) % 4;
      seg_raw[s*LVL_W +: LVL_W] = seg_level(nib_flat[bi], phase, bias_quarter);
    end
  end

  // R2: exactly one common selected in every slot
  a_r2_one_com: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1);
endmodule

// File: rtl/lcd_pin_mux.sv
module lcd_pin_mux
  import lcd_mux_pkg::*;
#(
  parameter int  NSEG       = 40,
  parameter int  NCOM       = 8,
  parameter int  SHARE_BASE = 16,
  localparam int NGRP       = (NSEG - SHARE_BASE) / 4,
  localparam int NSH        = NGRP * 4,
  localparam int NCGP       = NCOM / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  duty_quarter,
  input  logic [NCOM*LVL_W-1:0] com_raw,
  input  logic [NSEG*LVL_W-1:0] seg_raw,
  input  logic [NGRP-1:0]       grp_port,
  input  logic [NSH-1:0]        gp_wdata,
  input  logic                  com_gp_en,
  input  logic [NCGP-1:0]       com_pad_in,
  output logic [NCOM*LVL_W-1:0] com_lvl,
  output logic [NSEG*LVL_W-1:0] seg_lvl,
  output logic [NSH-1:0]        gp_drv,
  output logic [NCGP-1:0]       com_gp_rd
);
  assign com_lvl   = com_raw;
  assign com_gp_rd = (duty_quarter && com_gp_en) ? com_pad_in : '0;

  assign seg_lvl[SHARE_BASE*LVL_W-1:0] = seg_raw[SHARE_BASE*LVL_W-1:0];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = (SHARE_BASE + g*4) * LVL_W;
    assign seg_lvl[LO +: 4*LVL_W] = grp_port[g] ? {4{LVL_IDLE}} : seg_raw[LO +: 4*LVL_W];
    assign gp_drv[g*4 +: 4]       = grp_port[g] ? gp_wdata[g*4 +: 4] : 4'b0;
  end

  // R8: a common input reaches the reader only in quarter duty
  a_r8_com_input_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (com_gp_rd != '0) |-> (duty_quarter && com_gp_en));
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
  import lcd_mux_pkg::*;
#(
  parameter int         NSEG       = 40,
  parameter int         NCOM       = 8,
  parameter int         SHARE_BASE = 16,
  parameter int         SLOT_UNIT  = 8,
  parameter logic [9:0] RAM_BASE   = 10'h200,
  parameter logic [3:0] RATE_RST   = 4'b0111,
  localparam int        NGRP       = (NSEG - SHARE_BASE) / 4,
  localparam int        NSH        = NGRP * 4,
  localparam int        NCGP       = NCOM / 2,
  localparam int        SLOT_W     = $clog2(NCOM),
  localparam int        NNIB       = NSEG * (NCOM / 4)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  duty_quarter,
  input  logic                  bias_quarter,
  input  logic                  rate_we,
  input  logic [3:0]            rate_wdata,
  input  logic                  ram_we,
  input  logic [9:0]            ram_addr,
  input  logic [3:0]            ram_wdata,
  input  logic [NGRP-1:0]       seg_grp_port,
  input  logic [NSH-1:0]        seg_gp_wdata,
  input  logic                  com_gp_en,
  input  logic [NCGP-1:0]       com_pad_in,
  output logic [NCOM*LVL_W-1:0] com_lvl,
  output logic [NSEG*LVL_W-1:0] seg_lvl,
  output logic [NSH-1:0]        seg_gp_drv,
  output logic [NCGP-1:0]       com_gp_rd
);
  logic [3:0]            rate_q;
  logic [SLOT_W-1:0]     slot;
  logic                  phase, slot_end, frame_end;
  logic [NNIB*4-1:0]     nib_flat;
  logic [NCOM*LVL_W-1:0] com_raw;
  logic [NSEG*LVL_W-1:0] seg_raw;
  logic [NCOM-1:0]       com_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_q <= RATE_RST;
    else if (rate_we) rate_q <= rate_wdata;
  end

  lcd_frame_timer #(.NCOM(NCOM), .SLOT_UNIT(SLOT_UNIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .duty_quarter(duty_quarter), .rate(rate_q),
    .slot(slot), .phase(phase), .slot_end(slot_end), .frame_end(frame_end));

  lcd_seg_ram #(.NSEG(NSEG), .NCOM(NCOM), .ADDR_W(10), .BASE(RAM_BASE)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
    .nib_flat(nib_flat));

  lcd_level_gen #(.NSEG(NSEG), .NCOM(NCOM)) u_lvl (
    .clk(clk), .rst_n(rst_n), .slot(slot), .phase(phase),
    .duty_quarter(duty_quarter), .bias_quarter(bias_quarter), .nib_flat(nib_flat),
    .com_raw(com_raw), .seg_raw(seg_raw), .com_sel(com_sel));

  lcd_pin_mux #(.NSEG(NSEG), .NCOM(NCOM), .SHARE_BASE(SHARE_BASE)) u_pins (
    .clk(clk), .rst_n(rst_n), .duty_quarter(duty_quarter),
    .com_raw(com_raw), .seg_raw(seg_raw), .grp_port(seg_grp_port),
    .gp_wdata(seg_gp_wdata), .com_gp_en(com_gp_en), .com_pad_in(com_pad_in),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .gp_drv(seg_gp_drv), .com_gp_rd(com_gp_rd));

  // R1: the rate register comes out of reset at its default
  a_r1_rate_default: assert property (@(posedge clk)
    $fell(rst_n) |=> (rate_q == RATE_RST));
endmodule

// File: tb/lcd_mux_drv_tb.sv
module lcd_mux_drv_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         duty_quarter = 1'b0, bias_quarter = 1'b0;
  logic         rate_we = 1'b0;
  logic [3:0]   rate_wdata = '0;
  logic         ram_we = 1'b0;
  logic [9:0]   ram_addr = '0;
  logic [3:0]   ram_wdata = '0;
  logic [5:0]   seg_grp_port = '0;
  logic [23:0]  seg_gp_wdata = '0;
  logic         com_gp_en = 1'b0;
  logic [3:0]   com_pad_in = '0;
  logic [23:0]  com_lvl;
  logic [119:0] seg_lvl;
  logic [23:0]  seg_gp_drv;
  logic [3:0]   com_gp_rd;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  lcd_mux_drv #(.SLOT_UNIT(1)) u_dut (.*);

  // bench reference: slot counter, polarity and nibble store
  logic [3:0] ram_m [80];
  int         m_cnt, m_slot;
  logic       m_ph;
  logic [3:0] m_rate;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_slot <= 0; m_ph <= 1'b0; m_rate <= 4'd7;
    end else begin
      if (rate_we) m_rate <= rate_wdata;
      if (m_cnt >= int'(m_rate)) begin
        m_cnt <= 0;
        if (m_slot == (duty_quarter ? 3 : 7)) begin m_slot <= 0; m_ph <= ~m_ph; end
        else m_slot <= m_slot + 1;
      end else m_cnt <= m_cnt + 1;
    end
  end

  function automatic logic [2:0] e_com(int c);
    logic sel;
    if (duty_quarter && c >= 4) return 3'd0;
    sel = (c == m_slot);
    case ({bias_quarter, sel, m_ph})
      3'b111: return 3'd0; 3'b110: return 3'd4;
      3'b101: return 3'd3; 3'b100: return 3'd1;
      3'b011: return 3'd0; 3'b010: return 3'd3;
      3'b001: return 3'd2; default: return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] e_seg(int s);
    logic on;
    if (s >= 16 && seg_grp_port[(s-16)/4]) return 3'd0;
    on = ram_m[s*2 + m_slot/4][m_slot%4];
    case ({bias_quarter, on, m_ph})
      3'b111: return 3'd4; 3'b110: return 3'd0;
      3'b101, 3'b100: return 3'd2;
      3'b011: return 3'd3; 3'b010: return 3'd0;
      3'b001: return 3'd1; default: return 3'd2;
    endcase
  endfunction

  task automatic check_all(input string tag);
    int bad = 0;
    string msg = "";
    logic [23:0] e_drv;
    logic [3:0]  e_rd;
    for (int c = 0; c < 8; c++)
      if (com_lvl[c*3 +: 3] !== e_com(c)) begin
        if (bad == 0) msg = $sformatf("com%0d got %0d exp %0d", c, com_lvl[c*3 +: 3], e_com(c));
        bad++;
      end
    for (int s = 0; s < 40; s++)
      if (seg_lvl[s*3 +: 3] !== e_seg(s)) begin
        if (bad == 0) msg = $sformatf("seg%0d got %0d exp %0d", s, seg_lvl[s*3 +: 3], e_seg(s));
        bad++;
      end
    for (int g = 0; g < 6; g++) e_drv[g*4 +: 4] = seg_grp_port[g] ? seg_gp_wdata[g*4 +: 4] : 4'h0;
    if (seg_gp_drv !== e_drv) begin
      if (bad == 0) msg = $sformatf("gp_drv got %h exp %h", seg_gp_drv, e_drv);
      bad++;
    end
    e_rd = (duty_quarter && com_gp_en) ? com_pad_in : 4'h0;
    if (com_gp_rd !== e_rd) begin
      if (bad == 0) msg = $sformatf("com_gp_rd got %h exp %h", com_gp_rd, e_rd);
      bad++;
    end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s slot=%0d ph=%0d: %s", tag, m_slot, m_ph, msg);
    end
  endtask

  task automatic write_nib(input logic [9:0] a, input logic [3:0] d);
    @(negedge clk);
    ram_we = 1'b1; ram_addr = a; ram_wdata = d;
    if (a >= 10'h200 && a <= 10'h24F) ram_m[a - 10'h200] = d;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  // vector: {duty_quarter, bias_quarter, rate[3:0], grp[5:0], cgp_en, seed[7:0], ncyc[9:0]}
  localparam int NV = 6;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd7,  6'h00, 1'b1, 8'h35, 10'd140},
    {1'b0, 1'b0, 4'd2,  6'h15, 1'b0, 8'h5A, 10'd60},
    {1'b1, 1'b1, 4'd0,  6'h3F, 1'b1, 8'hC3, 10'd20},
    {1'b1, 1'b0, 4'd3,  6'h2A, 1'b0, 8'h77, 10'd50},
    {1'b0, 1'b0, 4'd15, 6'h00, 1'b0, 8'h11, 10'd270},
    {1'b1, 1'b0, 4'd7,  6'h01, 1'b1, 8'h9E, 10'd80}
  };

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      logic [7:0] seed;
      logic [3:0] rate;
      @(negedge clk);
      rst_n = 1'b0;
      {duty_quarter, bias_quarter, rate, seg_grp_port, com_gp_en, seed} = VEC[v][30:10];
      seg_gp_wdata = {seed, ~seed, seed};
      com_pad_in   = seed[3:0] | 4'h1;
      for (int i = 0; i < 80; i++)
        write_nib(10'h200 + 10'(i), 4'(((i * int'(seed)) >> 2) ^ i));
      @(negedge clk);
      check_all("R1 reset slot0 phase0");               // R1 R6 R7 R8
      if (rate != 4'd7) begin rate_we = 1'b1; rate_wdata = rate; end
      rst_n = 1'b1;
      @(negedge clk);
      rate_we = 1'b0;
      check_all("R9 rate write");
      for (int k = 1; k < int'(VEC[v][9:0]); k++) begin
        @(negedge clk);
        check_all(duty_quarter ? "R2 R3 R4 R5 R7 R8 quarter duty" : "R2 R4 R5 R7 R8 eighth duty");
      end
    end

    // R6: writes just outside the window leave the display alone
    write_nib(10'h1FF, 4'hF);
    write_nib(10'h250, 4'hF);
    write_nib(10'h000, 4'hF);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check_all("R6 out-of-window write ignored");
    end
    // R6: last in-window nibble (segment 39, upper commons) updates
    write_nib(10'h24F, 4'hA);
    write_nib(10'h24E, 4'h5);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check_all("R6 top nibble write");
    end
    // R8: eighth duty blocks the common inputs
    @(negedge clk);
    duty_quarter = 1'b0; rst_n = 1'b0; com_gp_en = 1'b1; com_pad_in = 4'hF;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check_all("R8 inputs blocked in eighth duty");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule